// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. A free-running clock divider makes a sample tick. The divider has two stages: a selectable power-of-two prescaler followed by an 8-bit reload counter. The receive engine samples the line sixteen times per bit period. It confirms a start bit at its middle and then takes every data, parity and stop bit at its centre, least significant data bit first. Character length, parity, stop count, divider setting, ready-to-send behaviour, the address-filter sleep mode and the interrupt policy all come from static configuration inputs.

Each completed character goes into a one-deep holding register, together with its parity and framing status. A read strobe empties the register. If a second character arrives before the read, the overrun flag is raised and the held character is kept. A one-cycle interrupt pulse marks either every accepted character or only the faulty ones. An active-low ready-to-send output tells the far end whether there is room.

Top module: `serial_rx_unit`

## Requirements
- R1: Character length comes from `mode_sel`: 3'b100 gives 7 data bits, 3'b110 gives 9 data bits, and any other code gives 8 data bits. Data arrives least significant bit first and is presented right-aligned in `rx_data`, with unused upper bits at zero.
- R2: With `par_en`=1, one parity bit follows the data. `par_even`=1 expects an even count of ones over data plus parity, and `par_even`=0 expects an odd count. A mismatch sets `err_parity` along with the character.
- R3: `stop2`=0 expects one stop bit and `stop2`=1 expects two. If any expected stop bit samples low, `err_frame` is set.
- R4: `src_sel` picks a prescale ratio of 2, 16, 64 or 512 (codes 00, 01, 10, 11). The reload divider then emits one sample tick every `baud_div`+1 prescaled pulses. One bit lasts 16 sample ticks. The first tick falls on the 2^k-th clock after reset. A character appears in `rx_valid` two clocks after the tick that samples its last stop bit.
- R5: A frame starts only on a falling line edge seen at a sample tick while `rx_en`=1. If the line is high again 8 ticks after detection, the start is dropped and nothing is received.
- R6: An accepted character sets `rx_valid`. A `rd_strobe` clears `rx_valid`, `err_parity`, `err_frame` and `err_overrun`.
- R7: A character that completes while `rx_valid`=1 and no read is under way sets `err_overrun`. `rx_data`, `err_parity` and `err_frame` keep the earlier character's values.
- R8: A read strobe in the same cycle as a completion empties the old character and stores the new one without overrun.
- R9: With `irq_on_err`=0, `irq` pulses high for exactly one cycle for every accepted character, overrun included.
- R10: With `irq_on_err`=1, `irq` pulses only for an accepted character that sets a parity, framing or overrun flag.
- R11: With `rts_en`=1, `rts_n` is low exactly when `rx_en`=1 and `rx_valid`=0. With `rts_en`=0, `rts_n` stays low.
- R12: With `sleep_en`=1 and 9-bit characters, a character whose bit 8 is 0 is dropped: no flag changes and no interrupt. A character with bit 8 set is accepted. In 7- and 8-bit modes, `sleep_en` has no effect.
- R13: After reset, `rx_data` is zero and `rx_valid`, all error flags and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, already synchronous to clk |
| rx_en | input | 1 | Allows new frames to start |
| mode_sel | input | 3 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| stop2 | input | 1 | 1 = two stop bits |
| src_sel | input | 2 | Prescaler ratio select |
| baud_div | input | 8 | Divider reload value |
| rts_en | input | 1 | Enables the ready-to-send output |
| sleep_en | input | 1 | Address-filter sleep mode |
| irq_on_err | input | 1 | 1 = interrupt on faulty characters only |
| rd_strobe | input | 1 | Consumes the held character |
| rx_data | output | 9 | Held character |
| rx_valid | output | 1 | Holding register full |
| err_parity | output | 1 | Parity mismatch on held character |
| err_frame | output | 1 | Stop bit sampled low |
| err_overrun | output | 1 | Character lost while register full |
| irq | output | 1 | One-cycle receive request |
| rts_n | output | 1 | Active-low ready to send |

## Verification
A consumer's read strobe and a newly completed character can reach the holding register in the same clock. The bench counts sample ticks to find the tick that takes the final stop bit. It raises the read strobe for exactly the cycle in which the finished character is handed over, while an earlier character is still held. It then expects the new character in `rx_data`, `rx_valid` still high and no overrun. A separate run sends two characters with no read between them; this one must show the overrun and the old data.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned CHAR_MAX = 9;
    localparam int unsigned LEN_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                par_bad;
        logic                stop_bad;
    } rx_char_t;

    // character length from the mode code; unknown codes fall back to 8
    function automatic logic [LEN_W-1:0] char_len(input logic [2:0] code);
        case (code)
            3'b100:  return LEN_W'(7);
            3'b110:  return LEN_W'(9);
            default: return LEN_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
    parameter int unsigned DIV_W    = 8,
    parameter int unsigned PS_W     = 9,
    parameter logic [15:0] PS_SHIFT = {4'd9, 4'd6, 4'd4, 4'd1}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       src_sel,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [DIV_W-1:0] div;
    } baud_t;

    baud_t           bq, bd;
    logic [3:0]      shift;
    logic [PS_W-1:0] mask;
    logic            ps_tick;

    always_comb begin
        shift = PS_SHIFT[{src_sel, 2'b00} +: 4];
        for (int i = 0; i < PS_W; i++) begin
            mask[i] = (i < int'(shift));
        end
        ps_tick = ((bq.ps & mask) == mask);

        bd    = bq;
        bd.ps = bq.ps + 1'b1;
        tick  = 1'b0;
        if (ps_tick) begin
            if (bq.div == '0) begin
                tick   = 1'b1;
                bd.div = reload;
            end else begin
                bd.div = bq.div - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bq <= '0;
        end else begin
            bq <= bd;
        end
    end

endmodule

// File: rtl/srx_frame.sv
module srx_frame
    import srx_pkg::*;
#(
    parameter int unsigned OSR = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic             rx_en,
    input  logic [LEN_W-1:0] len,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             stop2,
    output logic             done,
    output rx_char_t         result
);

    localparam int unsigned OS_W = $clog2(OSR);
    localparam int unsigned HALF = OSR / 2;

    typedef struct packed {
        rx_state_e           st;
        logic [OS_W-1:0]     os;
        logic [LEN_W-1:0]    idx;
        logic [CHAR_MAX-1:0] sh;
        logic                pbad;
        logic                fbad;
        logic                more_stop;
        logic                prev;
        logic                done;
        rx_char_t            res;
    } frame_t;

    frame_t fq, fd;
    logic   centre;
    logic   par_exp;
    logic   stop_fail;

    always_comb begin
        fd        = fq;
        fd.done   = 1'b0;
        centre    = (fq.os == OS_W'(OSR - 1));
        par_exp   = par_even ? (^fq.sh) : ~(^fq.sh);
        stop_fail = fq.fbad | ~rxd;

        if (tick) begin
            fd.prev = rxd;
            case (fq.st)
                ST_IDLE: begin
                    if (rx_en && fq.prev && !rxd) begin
                        fd.st = ST_START;
                        fd.os = '0;
                    end
                end
                ST_START: begin
                    if (fq.os == OS_W'(HALF - 1)) begin
                        fd.os = '0;
                        if (!rxd) begin
                            fd.st   = ST_DATA;
                            fd.idx  = '0;
                            fd.sh   = '0;
                            fd.pbad = 1'b0;
                            fd.fbad = 1'b0;
                        end else begin
                            fd.st = ST_IDLE;
                        end
                    end else begin
                        fd.os = fq.os + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (centre) begin
                        fd.os          = '0;
                        fd.sh[fq.idx]  = rxd;
                        if (fq.idx == len - LEN_W'(1)) begin
                            fd.st        = par_en ? ST_PAR : ST_STOP;
                            fd.more_stop = stop2;
                        end else begin
                            fd.idx = fq.idx + 1'b1;
                        end
                    end else begin
                        fd.os = fq.os + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (centre) begin
                        fd.os   = '0;
                        fd.pbad = (rxd != par_exp);
                        fd.st   = ST_STOP;
                    end else begin
                        fd.os = fq.os + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (centre) begin
                        fd.os = '0;
                        if (fq.more_stop) begin
                            fd.more_stop = 1'b0;
                            fd.fbad      = stop_fail;
                        end else begin
                            fd.done         = 1'b1;
                            fd.res.data     = fq.sh;
                            fd.res.par_bad  = fq.pbad;
                            fd.res.stop_bad = stop_fail;
                            fd.st           = ST_IDLE;
                        end
                    end else begin
                        fd.os = fq.os + 1'b1;
                    end
                end
                default: fd.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fq      <= '0;
            fq.st   <= ST_IDLE;
            fq.prev <= 1'b1;
        end else begin
            fq <= fd;
        end
    end

    assign done   = fq.done;
    assign result = fq.res;

endmodule

// File: rtl/srx_hold.sv
module srx_hold
    import srx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  rx_char_t            char_in,
    input  logic                sleep_on,
    input  logic                irq_on_err,
    input  logic                rd_strobe,
    input  logic                rx_en,
    input  logic                rts_en,
    output logic [CHAR_MAX-1:0] data,
    output logic                valid,
    output logic                perr,
    output logic                ferr,
    output logic                ovr,
    output logic                irq,
    output logic                rts_n
);

    typedef struct packed {
        logic [CHAR_MAX-1:0] data;
        logic                valid;
        logic                perr;
        logic                ferr;
        logic                ovr;
        logic                irq;
    } hold_t;

    hold_t hq, hd;
    logic  accept;
    logic  still_full;

    always_comb begin
        hd         = hq;
        hd.irq     = 1'b0;
        accept     = done && !(sleep_on && !char_in.data[CHAR_MAX-1]);
        still_full = hq.valid && !rd_strobe;

        if (rd_strobe) begin
            hd.valid = 1'b0;
            hd.perr  = 1'b0;
            hd.ferr  = 1'b0;
            hd.ovr   = 1'b0;
        end

        if (accept) begin
            if (still_full) begin
                hd.ovr = 1'b1;
                hd.irq = 1'b1;
            end else begin
                hd.data  = char_in.data;
                hd.valid = 1'b1;
                hd.perr  = char_in.par_bad;
                hd.ferr  = char_in.stop_bad;
                hd.irq   = irq_on_err ? (char_in.par_bad | char_in.stop_bad) : 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq <= '0;
        end else begin
            hq <= hd;
        end
    end

    assign data  = hq.data;
    assign valid = hq.valid;
    assign perr  = hq.perr;
    assign ferr  = hq.ferr;
    assign ovr   = hq.ovr;
    assign irq   = hq.irq;
    assign rts_n = rts_en ? !(rx_en && !hq.valid) : 1'b0;

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int unsigned DIV_W = 8,
    parameter int unsigned OSR   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd,
    input  logic                rx_en,
    input  logic [2:0]          mode_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                stop2,
    input  logic [1:0]          src_sel,
    input  logic [DIV_W-1:0]    baud_div,
    input  logic                rts_en,
    input  logic                sleep_en,
    input  logic                irq_on_err,
    input  logic                rd_strobe,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                err_parity,
    output logic                err_frame,
    output logic                err_overrun,
    output logic                irq,
    output logic                rts_n
);

    logic             sample_tick;
    logic             frm_done;
    rx_char_t         frm_char;
    logic [LEN_W-1:0] len;
    logic             sleep_on;

    assign len      = char_len(mode_sel);
    assign sleep_on = sleep_en && (len == LEN_W'(CHAR_MAX));

    srx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_sel (src_sel),
        .reload  (baud_div),
        .tick    (sample_tick)
    );

    srx_frame #(.OSR(OSR)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .rxd      (rxd),
        .rx_en    (rx_en),
        .len      (len),
        .par_en   (par_en),
        .par_even (par_even),
        .stop2    (stop2),
        .done     (frm_done),
        .result   (frm_char)
    );

    srx_hold u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (frm_done),
        .char_in    (frm_char),
        .sleep_on   (sleep_on),
        .irq_on_err (irq_on_err),
        .rd_strobe  (rd_strobe),
        .rx_en      (rx_en),
        .rts_en     (rts_en),
        .data       (rx_data),
        .valid      (rx_valid),
        .perr       (err_parity),
        .ferr       (err_frame),
        .ovr        (err_overrun),
        .irq        (irq),
        .rts_n      (rts_n)
    );

endmodule

// File: rtl/srx_props.sv
module srx_props (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe,
    input logic       irq_on_err,
    input logic       frm_done,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       irq
);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frm_done) |=> !rx_valid);

    // R6
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity || err_frame || err_overrun) |-> rx_valid);

    // R7
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_strobe) |=> $stable(rx_data));

    // R7
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rd_strobe) |=> rx_valid);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(frm_done));

    // R10
    irq_err_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_on_err)) |-> (err_parity || err_frame || err_overrun));

endmodule

bind serial_rx_unit srx_props u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe   (rd_strobe),
    .irq_on_err  (irq_on_err),
    .frm_done    (frm_done),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .irq         (irq)
);

// File: tb/serial_rx_unit_test.sv
module serial_rx_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic [2:0] mode_sel = 3'b101;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       stop2 = 1'b0;
    logic [1:0] src_sel = 2'b00;
    logic [7:0] baud_div = 8'd0;
    logic       rts_en = 1'b1;
    logic       sleep_en = 1'b0;
    logic       irq_on_err = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       err_parity;
    logic       err_frame;
    logic       err_overrun;
    logic       irq;
    logic       rts_n;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tcount = 0;
    int irq_cnt = 0;
    bit running = 1'b0;

    serial_rx_unit uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .mode_sel(mode_sel),
        .par_en(par_en), .par_even(par_even), .stop2(stop2), .src_sel(src_sel),
        .baud_div(baud_div), .rts_en(rts_en), .sleep_en(sleep_en),
        .irq_on_err(irq_on_err), .rd_strobe(rd_strobe), .rx_data(rx_data),
        .rx_valid(rx_valid), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun), .irq(irq), .rts_n(rts_n)
    );

    always #4 clk = ~clk;

    // tick schedule from the R4 rule: first at clock 2^k-1, then every 2^k*(n+1)
    function automatic bit is_tick(int c);
        int k;
        int p;
        int per;
        k   = (src_sel == 2'd0) ? 1 : (src_sel == 2'd1) ? 4 : (src_sel == 2'd2) ? 6 : 9;
        p   = 1 << k;
        per = p * (int'(baud_div) + 1);
        return (c >= p - 1) && (((c - (p - 1)) % per) == 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= 0;
            tcount <= 0;
        end else begin
            if (is_tick(cyc)) tcount <= tcount + 1;
            cyc <= cyc + 1;
            if (irq) irq_cnt <= irq_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // R11 compared on every clock
    always @(negedge clk) begin
        if (running && rst_n) begin
            chk("R11", "rts_n", int'(rts_n),
                rts_en ? int'(!(rx_en && !rx_valid)) : 0);
        end
    end

    task automatic wait_until(input int tgt);
        while (tcount < tgt) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] val, input int len, input bit bad_par,
                              input bit stop_low, input bit rd_at_end, input bit time_chk);
        bit bits[$];
        int ones;
        int t0;
        int n;
        bit pb;
        ones = 0;
        for (int i = 0; i < len; i++) begin
            bits.push_back(val[i]);
            ones += int'(val[i]);
        end
        if (par_en) begin
            pb = par_even ? bit'(ones & 1) : !bit'(ones & 1);
            if (bad_par) pb = !pb;
            bits.push_back(pb);
        end
        bits.push_back(!(stop_low && !stop2));
        if (stop2) bits.push_back(!stop_low);
        n = bits.size();
        @(negedge clk);
        t0  = tcount;
        rxd = 1'b0;
        for (int j = 0; j < n; j++) begin
            wait_until(t0 + 16 * (j + 1));
            rxd = bits[j];
        end
        if (rd_at_end || time_chk) begin
            wait_until(t0 + 9 + 16 * n);
            if (time_chk) chk("R4", "valid one clock after last stop tick", int'(rx_valid), 0);
            if (rd_at_end) rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            if (time_chk) chk("R4", "valid two clocks after last stop tick", int'(rx_valid), 1);
        end
        wait_until(t0 + 16 * (n + 1));
        rxd = 1'b1;
        wait_until(t0 + 16 * (n + 1) + 2);
    endtask

    initial begin
        int base;
        do_reset();
        @(negedge clk);
        running = 1'b1;
        chk("R13", "data after reset", int'(rx_data), 0);
        chk("R13", "valid after reset", int'(rx_valid), 0);
        chk("R13", "flags after reset", int'({err_parity, err_frame, err_overrun}), 0);
        chk("R13", "irq after reset", int'(irq), 0);

        // 8-bit plain character with cycle timing
        base = irq_cnt;
        send_frame(9'h0A5, 8, 0, 0, 0, 1);
        chk("R1", "8-bit data", int'(rx_data), 'h0A5);
        chk("R9", "irq per char", irq_cnt - base, 1);
        do_read();
        chk("R6", "valid after read", int'(rx_valid), 0);

        // 7-bit
        mode_sel = 3'b100;
        send_frame(9'h05B, 7, 0, 0, 0, 0);
        chk("R1", "7-bit data", int'(rx_data), 'h05B);
        do_read();

        // 9-bit
        mode_sel = 3'b110;
        send_frame(9'h1C3, 9, 0, 0, 0, 0);
        chk("R1", "9-bit data", int'(rx_data), 'h1C3);
        do_read();

        // unknown mode code behaves as 8 bits
        mode_sel = 3'b000;
        send_frame(9'h0E1, 8, 0, 0, 0, 0);
        chk("R1", "default 8-bit data", int'(rx_data), 'h0E1);
        do_read();
        mode_sel = 3'b101;

        // parity
        par_en = 1'b1; par_even = 1'b1;
        send_frame(9'h037, 8, 0, 0, 0, 0);
        chk("R2", "even parity good", int'(err_parity), 0);
        chk("R2", "even parity data", int'(rx_data), 'h037);
        do_read();
        par_even = 1'b0;
        send_frame(9'h037, 8, 1, 0, 0, 0);
        chk("R2", "odd parity bad", int'(err_parity), 1);
        do_read();
        chk("R6", "parity flag cleared by read", int'(err_parity), 0);
        send_frame(9'h0F0, 8, 0, 0, 0, 0);
        chk("R2", "odd parity good", int'(err_parity), 0);
        do_read();
        par_en = 1'b0;

        // stop bits
        stop2 = 1'b1;
        send_frame(9'h066, 8, 0, 0, 0, 0);
        chk("R3", "two stops good", int'(err_frame), 0);
        do_read();
        send_frame(9'h066, 8, 0, 1, 0, 0);
        chk("R3", "second stop low", int'(err_frame), 1);
        do_read();
        stop2 = 1'b0;
        send_frame(9'h099, 8, 0, 1, 0, 0);
        chk("R3", "single stop low", int'(err_frame), 1);
        do_read();

        // overrun
        base = irq_cnt;
        send_frame(9'h011, 8, 0, 0, 0, 0);
        send_frame(9'h022, 8, 0, 0, 0, 0);
        chk("R7", "overrun flag", int'(err_overrun), 1);
        chk("R7", "old data kept", int'(rx_data), 'h011);
        chk("R7", "valid kept", int'(rx_valid), 1);
        chk("R9", "irq on both chars", irq_cnt - base, 2);
        do_read();
        chk("R6", "overrun cleared", int'(err_overrun), 0);

        // read in the completion cycle
        send_frame(9'h033, 8, 0, 0, 0, 0);
        send_frame(9'h044, 8, 0, 0, 1, 0);
        chk("R8", "new data stored", int'(rx_data), 'h044);
        chk("R8", "no overrun", int'(err_overrun), 0);
        chk("R8", "valid stays", int'(rx_valid), 1);
        do_read();

        // interrupt on errors only
        irq_on_err = 1'b1;
        base = irq_cnt;
        send_frame(9'h055, 8, 0, 0, 0, 0);
        chk("R10", "no irq on clean char", irq_cnt - base, 0);
        do_read();
        par_en = 1'b1;
        send_frame(9'h055, 8, 1, 0, 0, 0);
        chk("R10", "irq on parity error", irq_cnt - base, 1);
        do_read();
        par_en = 1'b0;
        irq_on_err = 1'b0;

        // receive disabled
        rx_en = 1'b0;
        @(negedge clk);
        chk("R11", "rts high when disabled", int'(rts_n), 1);
        send_frame(9'h0C3, 8, 0, 0, 0, 0);
        chk("R5", "no start while disabled", int'(rx_valid), 0);
        rx_en = 1'b1;

        // short low pulse rejected
        begin
            int t0;
            @(negedge clk);
            t0 = tcount;
            rxd = 1'b0;
            wait_until(t0 + 3);
            rxd = 1'b1;
            wait_until(t0 + 40);
            chk("R5", "glitch ignored", int'(rx_valid), 0);
        end

        // sleep filter
        mode_sel = 3'b110; sleep_en = 1'b1;
        base = irq_cnt;
        send_frame(9'h0AA, 9, 0, 0, 0, 0);
        chk("R12", "bit8 low dropped", int'(rx_valid), 0);
        chk("R12", "no irq on drop", irq_cnt - base, 0);
        send_frame(9'h155, 9, 0, 0, 0, 0);
        chk("R12", "bit8 high kept", int'(rx_data), 'h155);
        do_read();
        mode_sel = 3'b101;
        send_frame(9'h012, 8, 0, 0, 0, 0);
        chk("R12", "sleep ignored in 8-bit", int'(rx_data), 'h012);
        sleep_en = 1'b0;

        // ready output disabled while full
        rts_en = 1'b0;
        @(negedge clk);
        chk("R11", "rts low when function off", int'(rts_n), 0);
        do_read();
        rts_en = 1'b1;

        // other divider settings
        src_sel = 2'b01; baud_div = 8'd2;
        do_reset();
        send_frame(9'h096, 8, 0, 0, 0, 1);
        chk("R4", "ratio 16 reload 2", int'(rx_data), 'h096);
        src_sel = 2'b10; baud_div = 8'd1;
        do_reset();
        send_frame(9'h03C, 8, 0, 0, 0, 1);
        chk("R4", "ratio 64 reload 1", int'(rx_data), 'h03C);

        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule